// File: doc/BRIEF.md
# Four-Digit Decimal Combination Lock Controller

This block is the control core of a push-button combination lock. Three buttons, all active low, drive it: an increment key, a confirm key and a check key. Each raw button first passes through a synchronizer. It then goes through a debouncer that counts sample ticks, such as a 1 kHz strobe from elsewhere on the chip. Each accepted press then becomes a single pulse in the system clock domain.

The increment key steps the newest entry digit through the decimal values 0 to 9. The confirm key pushes the digits one place older, so the code is keyed in oldest digit first.

A press of the check key compares the four entered digits with the stored code. It then sets one of two sticky outputs: unlocked on a match, alarm otherwise. The session enable input wipes the entry, the match flag and both verdicts while it is low. While the session is active, holding the change-code input high copies the entered digits into the stored code. After reset the stored code holds a fixed default.

Top module: `combo_lock`

## Requirements
- R1: After synchronous reset, entry_code is 0x0000 and match, unlocked and alarm are all 0.
- R2: A key is accepted only when it has been seen low continuously across DEB_TICKS (default 29) sample_tick strobes. One clock cycle in which the synchronized key is high restarts the count. Each accepted press produces exactly one event, however long the key is held.
- R3: An accepted increment press while sess_en is 1 adds one to the newest digit entry_code[3:0], and the value 9 wraps to 0.
- R4: An accepted confirm press while sess_en is 1 moves entry_code[11:8] to [15:12], [7:4] to [11:8] and [3:0] to [7:4]. It leaves [3:0] unchanged.
- R5: While sess_en is 0, on every clock edge entry_code, match, unlocked and alarm are cleared. Key presses have no effect on entry_code while sess_en is 0.
- R6: After reset the stored code equals entry value 0x8374: digit 8 in [15:12], 3 in [11:8], 7 in [7:4] and 4 in [3:0].
- R7: On a clock edge where chg_code and sess_en are both 1, the stored code becomes the current entry_code. Otherwise it holds.
- R8: One cycle after an accepted check press with sess_en at 1, match shows whether entry_code equalled the stored code at the time of the press.
- R9: In the cycle after match is updated, unlocked rises if match is 1 and alarm rises if match is 0, provided neither was already set.
- R10: unlocked and alarm are never 1 together. Once either is set, later check presses change neither of them until sess_en goes to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_tick | input | 1 | One-cycle strobe at the debounce sampling rate |
| sess_en | input | 1 | Session enable; low clears the entry and the verdicts |
| chg_code | input | 1 | Level request to copy the entry into the stored code |
| key_inc_n | input | 1 | Raw increment button, active low |
| key_cfm_n | input | 1 | Raw confirm button, active low |
| key_chk_n | input | 1 | Raw check button, active low |
| entry_code | output | 16 | Entered digits, newest in [3:0], oldest in [15:12] |
| match | output | 1 | Result of the latest comparison |
| unlocked | output | 1 | Sticky unlock verdict |
| alarm | output | 1 | Sticky wrong-code verdict |

## Verification
The assertions assume that sample_tick is a single-cycle strobe and that the raw keys are asynchronous levels. They also assume a key held low produces at most one accepted event per press, so several pulses may land in the same cycle only when different buttons are pressed together. The stimulus holds each key low well beyond DEB_TICKS strobes and releases it for longer than the synchronizer depth. It produces short glitches only in the tests that expect them to be ignored. sess_en and chg_code change only between clock edges, away from the cycles in which a check press is being judged.

// File: rtl/combo_lock_pkg.sv
package combo_lock_pkg;

  localparam int BCD_W = 4;

  // Button indices inside the front-end array
  localparam int KEY_INC = 0;
  localparam int KEY_CFM = 1;
  localparam int KEY_CHK = 2;
  localparam int N_KEYS  = 3;

  // Next value of a decimal digit, wrapping 9 back to 0
  function automatic logic [BCD_W-1:0] bcd_next(input logic [BCD_W-1:0] d);
    return (d >= 4'd9) ? 4'd0 : d + 4'd1;
  endfunction

  // Digit-wise equality of two packed decimal codes
  function automatic logic codes_equal(input logic [63:0] a,
                                       input logic [63:0] b,
                                       input int          n_digits);
    logic eq;
    eq = 1'b1;
    for (int i = 0; i < n_digits; i++) begin
      if (a[i*BCD_W +: BCD_W] != b[i*BCD_W +: BCD_W]) eq = 1'b0;
    end
    return eq;
  endfunction

endpackage

// File: rtl/lock_debounce.sv
module lock_debounce #(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_TICKS   = 29
) (
  input  logic clk,
  input  logic rst,
  input  logic sample_tick,
  input  logic key_n,
  output logic press_pulse
);
  localparam int CW = $clog2(DEB_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(DEB_TICKS - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   level_q;
  logic                   level_d1_q;
  logic                   key_down;

  // Synchronizer chain, idles released (high)
  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], key_n};
  end

  assign key_down = ~sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      level_q    <= 1'b0;
      level_d1_q <= 1'b0;
    end else begin
      level_d1_q <= level_q;
      if (!key_down) begin
        cnt_q   <= '0;
        level_q <= 1'b0;
      end else if (sample_tick) begin
        if (cnt_q == LAST) level_q <= 1'b1;
        else               cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

  assign press_pulse = level_q & ~level_d1_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    press_pulse |=> !press_pulse); // R2
  AST_RELEASE_DROPS: assert property (@(posedge clk) disable iff (rst)
    !key_down |=> !level_q); // R2
  AST_NO_TICK_NO_RISE: assert property (@(posedge clk) disable iff (rst)
    (!sample_tick && !level_q) |=> !level_q); // R2

endmodule

// File: rtl/lock_entry.sv
module lock_entry
  import combo_lock_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int CODE_W = DIGITS * BCD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sess_en,
  input  logic              inc_pulse,
  input  logic              cfm_pulse,
  output logic [CODE_W-1:0] code
);
  logic [BCD_W-1:0] dig_q [DIGITS];

  // Newest digit: the decimal counter
  always_ff @(posedge clk) begin
    if (rst || !sess_en)  dig_q[0] <= '0;
    else if (inc_pulse)   dig_q[0] <= bcd_next(dig_q[0]);
  end

  // Older digits: the shift history
  for (genvar g = 1; g < DIGITS; g++) begin : g_hist
    always_ff @(posedge clk) begin
      if (rst || !sess_en) dig_q[g] <= '0;
      else if (cfm_pulse)  dig_q[g] <= dig_q[g-1];
    end
  end

  for (genvar g = 0; g < DIGITS; g++) begin : g_pack
    assign code[g*BCD_W +: BCD_W] = dig_q[g];
    AST_DIGIT_DECIMAL: assert property (@(posedge clk) disable iff (rst)
      dig_q[g] <= 4'd9); // R3
  end

  AST_WRAP: assert property (@(posedge clk) disable iff (rst)
    (sess_en && inc_pulse && code[3:0] == 4'd9) |=> code[3:0] == 4'd0); // R3
  AST_STEP: assert property (@(posedge clk) disable iff (rst)
    (sess_en && inc_pulse && code[3:0] < 4'd9) |=> code[3:0] == $past(code[3:0]) + 4'd1); // R3
  AST_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (sess_en && cfm_pulse) |=> code[CODE_W-1:BCD_W] == $past(code[CODE_W-BCD_W-1:0])); // R4
  AST_NEWEST_KEPT: assert property (@(posedge clk) disable iff (rst)
    (sess_en && !inc_pulse) |=> $stable(code[3:0])); // R4
  AST_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !sess_en |=> code == '0); // R5

endmodule

// File: rtl/lock_codestore.sv
module lock_codestore
  import combo_lock_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int CODE_W = DIGITS * BCD_W,
  parameter logic [CODE_W-1:0] RESET_CODE = 16'h8374
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sess_en,
  input  logic              chg_code,
  input  logic [CODE_W-1:0] entry,
  output logic [CODE_W-1:0] stored
);
  logic load_now;
  assign load_now = chg_code & sess_en;

  always_ff @(posedge clk) begin
    if (rst)           stored <= RESET_CODE;
    else if (load_now) stored <= entry;
  end

  AST_LOAD: assert property (@(posedge clk) disable iff (rst)
    (chg_code && sess_en) |=> stored == $past(entry)); // R7
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(chg_code && sess_en) |=> $stable(stored)); // R7

endmodule

// File: rtl/lock_verdict.sv
module lock_verdict
  import combo_lock_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int CODE_W = DIGITS * BCD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sess_en,
  input  logic              chk_pulse,
  input  logic [CODE_W-1:0] entry,
  input  logic [CODE_W-1:0] stored,
  output logic              match,
  output logic              unlocked,
  output logic              alarm
);
  logic chk_seen_q;   // a comparison was captured last cycle
  logic decided;      // one of the verdicts is already set
  logic same_code;

  assign same_code = codes_equal(64'(entry), 64'(stored), DIGITS);
  assign decided   = unlocked | alarm;

  always_ff @(posedge clk) begin
    if (rst || !sess_en) begin
      chk_seen_q <= 1'b0;
      match      <= 1'b0;
    end else begin
      chk_seen_q <= chk_pulse;
      if (chk_pulse) match <= same_code;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !sess_en) begin
      unlocked <= 1'b0;
      alarm    <= 1'b0;
    end else if (chk_seen_q && !decided) begin
      unlocked <= match;
      alarm    <= ~match;
    end
  end

  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(unlocked && alarm)); // R10
  AST_STICKY_UNLOCK: assert property (@(posedge clk) disable iff (rst)
    (unlocked && sess_en) |=> unlocked); // R10
  AST_STICKY_ALARM: assert property (@(posedge clk) disable iff (rst)
    (alarm && sess_en) |=> alarm); // R10
  AST_VERDICT_OPEN: assert property (@(posedge clk) disable iff (rst)
    (chk_seen_q && !decided && sess_en && match) |=> unlocked); // R9
  AST_VERDICT_ALARM: assert property (@(posedge clk) disable iff (rst)
    (chk_seen_q && !decided && sess_en && !match) |=> alarm); // R9
  AST_MATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (sess_en && !chk_pulse) |=> $stable(match)); // R8
  AST_SESSION_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !sess_en |=> (!unlocked && !alarm && !match)); // R5

endmodule

// File: rtl/combo_lock.sv
module combo_lock
  import combo_lock_pkg::*;
#(
  parameter int DIGITS      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int DEB_TICKS   = 29,
  localparam int CODE_W = DIGITS * BCD_W,
  parameter logic [CODE_W-1:0] RESET_CODE = 16'h8374
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_tick,
  input  logic              sess_en,
  input  logic              chg_code,
  input  logic              key_inc_n,
  input  logic              key_cfm_n,
  input  logic              key_chk_n,
  output logic [CODE_W-1:0] entry_code,
  output logic              match,
  output logic              unlocked,
  output logic              alarm
);
  logic [N_KEYS-1:0] raw_keys_n;
  logic [N_KEYS-1:0] key_pulse;
  logic [CODE_W-1:0] stored_code;

  assign raw_keys_n[KEY_INC] = key_inc_n;
  assign raw_keys_n[KEY_CFM] = key_cfm_n;
  assign raw_keys_n[KEY_CHK] = key_chk_n;

  for (genvar k = 0; k < N_KEYS; k++) begin : g_key
    lock_debounce #(
      .SYNC_STAGES (SYNC_STAGES),
      .DEB_TICKS   (DEB_TICKS)
    ) u_deb (
      .clk         (clk),
      .rst         (rst),
      .sample_tick (sample_tick),
      .key_n       (raw_keys_n[k]),
      .press_pulse (key_pulse[k])
    );
  end

  lock_entry #(.DIGITS(DIGITS)) u_entry (
    .clk       (clk),
    .rst       (rst),
    .sess_en   (sess_en),
    .inc_pulse (key_pulse[KEY_INC]),
    .cfm_pulse (key_pulse[KEY_CFM]),
    .code      (entry_code)
  );

  lock_codestore #(.DIGITS(DIGITS), .RESET_CODE(RESET_CODE)) u_store (
    .clk      (clk),
    .rst      (rst),
    .sess_en  (sess_en),
    .chg_code (chg_code),
    .entry    (entry_code),
    .stored   (stored_code)
  );

  lock_verdict #(.DIGITS(DIGITS)) u_verdict (
    .clk       (clk),
    .rst       (rst),
    .sess_en   (sess_en),
    .chk_pulse (key_pulse[KEY_CHK]),
    .entry     (entry_code),
    .stored    (stored_code),
    .match     (match),
    .unlocked  (unlocked),
    .alarm     (alarm)
  );

endmodule

// File: tb/combo_lock_tb.sv
`timescale 1ns/1ps
module combo_lock_tb;
  localparam int DEB   = 29;
  localparam int TICKD = 4;
  localparam int HOLD  = (DEB + 4) * TICKD;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample_tick = 1'b0;
  logic sess_en = 1'b0, chg_code = 1'b0;
  logic key_inc_n = 1'b1, key_cfm_n = 1'b1, key_chk_n = 1'b1;
  logic [15:0] entry_code;
  logic match, unlocked, alarm;

  int n_checks = 0, n_fail = 0, cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  combo_lock u_dut (
    .clk(clk), .rst(rst), .sample_tick(sample_tick), .sess_en(sess_en),
    .chg_code(chg_code), .key_inc_n(key_inc_n), .key_cfm_n(key_cfm_n),
    .key_chk_n(key_chk_n), .entry_code(entry_code), .match(match),
    .unlocked(unlocked), .alarm(alarm)
  );

  // ---------------- behavioural reference model ----------------
  bit sy1[3], sy2[3], lvl[3], prv[3], pul[3], raw[3];
  int cnt[3];
  int dg[4], od[4], st[4];
  bit m_match, m_chkd, m_unl, m_alm, eq;

  function automatic logic [15:0] pack4(input int a3, input int a2, input int a1, input int a0);
    return {a3[3:0], a2[3:0], a1[3:0], a0[3:0]};
  endfunction

  always @(posedge clk) begin
    raw[0] = key_inc_n; raw[1] = key_cfm_n; raw[2] = key_chk_n;
    if (rst) begin
      for (int b = 0; b < 3; b++) begin
        sy1[b] = 1; sy2[b] = 1; lvl[b] = 0; prv[b] = 0; cnt[b] = 0;
      end
      for (int i = 0; i < 4; i++) dg[i] = 0;
      st[3] = 8; st[2] = 3; st[1] = 7; st[0] = 4;
      m_match = 0; m_chkd = 0; m_unl = 0; m_alm = 0;
    end else begin
      for (int b = 0; b < 3; b++) pul[b] = lvl[b] && !prv[b];
      eq = 1;
      for (int i = 0; i < 4; i++) if (dg[i] != st[i]) eq = 0;
      if (!sess_en) begin m_unl = 0; m_alm = 0; end
      else if (m_chkd && !m_unl && !m_alm) begin
        if (m_match) m_unl = 1; else m_alm = 1;
      end
      if (!sess_en) m_match = 0; else if (pul[2]) m_match = eq;
      m_chkd = pul[2] && sess_en;
      if (chg_code && sess_en) for (int i = 0; i < 4; i++) st[i] = dg[i];
      if (!sess_en) for (int i = 0; i < 4; i++) dg[i] = 0;
      else begin
        for (int i = 0; i < 4; i++) od[i] = dg[i];
        if (pul[1]) begin dg[3] = od[2]; dg[2] = od[1]; dg[1] = od[0]; end
        if (pul[0]) dg[0] = (od[0] + 1) % 10;
      end
      for (int b = 0; b < 3; b++) begin
        prv[b] = lvl[b];
        if (sy2[b]) begin cnt[b] = 0; lvl[b] = 0; end
        else if (sample_tick) begin
          if (cnt[b] == DEB - 1) lvl[b] = 1; else cnt[b]++;
        end
        sy2[b] = sy1[b]; sy1[b] = raw[b];
      end
    end
  end

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!done && cycles > 0) begin
      n_checks++;
      if (entry_code !== pack4(dg[3], dg[2], dg[1], dg[0])) begin
        n_fail++;
        $display("FAIL R3 R4 model entry_code act=%h exp=%h", entry_code, pack4(dg[3], dg[2], dg[1], dg[0]));
      end
      if ({match, unlocked, alarm} !== {m_match, m_unl, m_alm}) begin
        n_fail++;
        $display("FAIL R8 R9 model match/unlocked/alarm act=%b exp=%b",
                 {match, unlocked, alarm}, {m_match, m_unl, m_alm});
      end
    end
  end

  // Sample strobe generator and watchdog
  initial begin
    int t = 0;
    forever begin
      @(negedge clk);
      t++;
      sample_tick = (t % TICKD == 0);
    end
  end

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired act=%0d exp=<150000", cycles);
      report();
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_key(input int b, input logic v);
    case (b)
      0: key_inc_n = v;
      1: key_cfm_n = v;
      default: key_chk_n = v;
    endcase
  endtask

  task automatic press(input int b);
    @(negedge clk); drive_key(b, 1'b0);
    wait_cyc(HOLD);
    drive_key(b, 1'b1);
    wait_cyc(12);
  endtask

  task automatic press_n(input int b, input int n);
    for (int i = 0; i < n; i++) press(b);
  endtask

  task automatic chk16(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk3(input string req, input logic [2:0] exp);
    n_checks++;
    if ({match, unlocked, alarm} !== exp) begin
      n_fail++;
      $display("FAIL %s match/unlocked/alarm act=%b exp=%b", req, {match, unlocked, alarm}, exp);
    end
  endtask

  // ---------------- scenario ----------------
  initial begin
    wait_cyc(5);
    chk16("R1 reset entry", entry_code, 16'h0000);
    chk3("R1 reset flags", 3'b000);
    @(negedge clk); rst = 1'b0;
    @(negedge clk); sess_en = 1'b1;
    wait_cyc(4);

    // R2: short glitch is ignored
    @(negedge clk); key_inc_n = 1'b0; wait_cyc(50); key_inc_n = 1'b1; wait_cyc(12);
    chk16("R2 glitch ignored", entry_code, 16'h0000);
    // R2: a brief release restarts the count
    @(negedge clk); key_inc_n = 1'b0; wait_cyc(100); key_inc_n = 1'b1;
    wait_cyc(3); key_inc_n = 1'b0; wait_cyc(100); key_inc_n = 1'b1; wait_cyc(12);
    chk16("R2 restart on release", entry_code, 16'h0000);
    // R2: long hold counts once
    @(negedge clk); key_inc_n = 1'b0; wait_cyc(HOLD * 3); key_inc_n = 1'b1; wait_cyc(12);
    chk16("R2 one event per press", entry_code, 16'h0001);

    // R3: step to 9 then wrap
    press_n(0, 8);
    chk16("R3 count to nine", entry_code, 16'h0009);
    press(0);
    chk16("R3 wrap to zero", entry_code, 16'h0000);

    // R4 and R6: key in 8,3,7,4
    press_n(0, 8); press(1);
    chk16("R4 first shift", entry_code, 16'h0088);
    press_n(0, 5); press(1);
    chk16("R4 second shift", entry_code, 16'h0833);
    press_n(0, 4); press(1);
    press_n(0, 7);
    chk16("R4 full entry", entry_code, 16'h8374);
    press(2);
    chk3("R6 default code unlocks", 3'b110);
    chk3("R8 match flag set", 3'b110);

    // R10: later wrong check leaves verdict alone
    press(0);
    chk16("R10 entry altered", entry_code, 16'h8375);
    press(2);
    chk3("R10 sticky unlocked", 3'b010);

    // R5: session drop clears; keys ignored meanwhile
    @(negedge clk); sess_en = 1'b0; wait_cyc(2);
    chk16("R5 entry cleared", entry_code, 16'h0000);
    chk3("R5 flags cleared", 3'b000);
    press(0); press(1);
    chk16("R5 keys ignored", entry_code, 16'h0000);

    // R9: wrong code raises alarm
    @(negedge clk); sess_en = 1'b1; wait_cyc(2);
    press(2);
    chk3("R9 alarm on mismatch", 3'b001);

    // R7: change code to 0x0000, alarm stays sticky
    @(negedge clk); chg_code = 1'b1; @(negedge clk); chg_code = 1'b0;
    press(2);
    chk3("R10 sticky alarm", 3'b101);
    @(negedge clk); sess_en = 1'b0; wait_cyc(2); sess_en = 1'b1; wait_cyc(2);
    press(2);
    chk3("R7 new code unlocks", 3'b110);

    // R7: old default no longer opens
    @(negedge clk); sess_en = 1'b0; wait_cyc(2); sess_en = 1'b1; wait_cyc(2);
    press_n(0, 8); press(1); press_n(0, 5); press(1); press_n(0, 4); press(1); press_n(0, 7);
    chk16("R7 default re-entered", entry_code, 16'h8374);
    press(2);
    chk3("R7 old default rejected", 3'b001);

    wait_cyc(5);
    report();
  end

endmodule